// File: doc/BRIEF.md
# SIMD Word-to-Halfword Access Sequencer

This block sits between a core issuing 64-bit SIMD memory accesses and a 16-bit external memory controller. A SIMD access carries two 32-bit words. The explicit word is at the given logical word address, and the implicit word is at the next logical word address. The block turns the access into halfword traffic on the external side. It translates the address, orders the four halfwords and groups them into memory commands in the way the selected memory type expects.

One memory type is single-data-rate. For it, the access becomes four single-halfword commands at consecutive physical addresses, each followed by its one data beat. The other type is double-data-rate with a burst length of four. For it, the access becomes one burst command at the start address, followed by four data beats. Read beats are gathered back into a 64-bit word. That word is returned to the core with a one-cycle valid pulse.

Top module: `simd_x16_seq`

## Requirements
- R1: The physical halfword address of the explicit word is twice its logical word address. For example, logical 0x200000 gives physical 0x400000.
- R2: Halfwords move in this order: explicit low, explicit high, implicit low, implicit high. They go to physical N, N+1, N+2 and N+3. Bits [31:0] of the 64-bit core data hold the explicit word, and bits [63:32] hold the implicit word.
- R3: When `req_ddr_i`=0, an access issues exactly four commands with `cmd_burst_o`=0. Their addresses are N, N+1, N+2 and N+3, and each command is followed by exactly one data beat.
- R4: When `req_ddr_i`=1, an access issues exactly one command with `cmd_burst_o`=1 at address N, followed by four data beats.
- R5: Every write beat is driven with `wbeat_mask_o`=2'b00, meaning no halfword lane is masked.
- R6: A command stays valid, with its address unchanged, until the cycle in which `cmd_ack_i` is high.
- R7: `req_ready_o` falls in the cycle after a request is accepted. For a write it stays low until the fourth write beat is accepted. For a read it stays low until the fourth read beat has been captured and the response has been given.
- R8: A read returns one cycle of `rsp_valid_o`. In that cycle `rsp_rdata_o` = {beat3, beat2, beat1, beat0}, and `req_ready_o` goes high in the following cycle.
- R9: While reset is asserted, `req_ready_o`=1 and `cmd_valid_o`, `wbeat_valid_o` and `rsp_valid_o` are all 0.
- R10: `cmd_we_o` is 1 on every command of a write access and 0 on every command of a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_addr_i | input | LADDR_W | Logical word address of the explicit word |
| req_wdata_i | input | DATA_W | Write data, implicit word in the upper half |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_ddr_i | input | 1 | 1 = burst-of-four memory, 0 = single-beat memory |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| rsp_rdata_o | output | DATA_W | Assembled read data |
| cmd_valid_o | output | 1 | Memory command valid |
| cmd_ack_i | input | 1 | Memory command accepted |
| cmd_we_o | output | 1 | Command is a write |
| cmd_burst_o | output | 1 | Command covers four beats |
| cmd_addr_o | output | LADDR_W+1 | Physical halfword address |
| wbeat_valid_o | output | 1 | Write beat valid |
| wbeat_ready_i | input | 1 | Write beat accepted |
| wbeat_data_o | output | BEAT_W | Write beat data |
| wbeat_mask_o | output | BEAT_W/8 | Write byte mask, 1 = masked |
| rbeat_valid_i | input | 1 | Read beat valid |
| rbeat_data_i | input | BEAT_W | Read beat data |

## Verification
The hardest case is a command that has to wait. The address must stay fixed while `cmd_ack_i` is low, and in single-beat mode the address still has to advance by one per command. The memory model acknowledges commands only on every third cycle and accepts write beats only on every other cycle, so most commands stall for one or two cycles. A monitor flags any command that drops or changes address before it is acknowledged. Cross-mode reads check that data written in one mode comes back in the other, which confirms that the halfword placement is the same for both memory types.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_RESP
  } seq_state_e;
endpackage

// File: rtl/simd_seq_ctrl.sv
module simd_seq_ctrl
  import simd_seq_pkg::*;
#(
  parameter int NBEAT = 4,
  parameter int CNT_W = $clog2(NBEAT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             req_ddr_i,
  input  logic             cmd_ack_i,
  input  logic             wbeat_ready_i,
  input  logic             rbeat_valid_i,
  output logic             req_ready_o,
  output logic             load_o,
  output logic             we_o,
  output logic             burst_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cmd_valid_o,
  output logic             wbeat_valid_o,
  output logic             rcap_o,
  output logic             rsp_valid_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             we_q, burst_q;
  logic             beat_done, last_beat;

  assign load_o    = req_valid_i && (state_q == ST_IDLE);
  assign last_beat = (cnt_q == CNT_W'(NBEAT - 1));
  assign beat_done = (state_q == ST_DATA) && (we_q ? wbeat_ready_i : rbeat_valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (load_o) begin
          we_q    <= req_we_i;
          burst_q <= req_ddr_i;
          cnt_q   <= '0;
          state_q <= ST_CMD;
        end
        ST_CMD: if (cmd_ack_i) state_q <= ST_DATA;
        ST_DATA: if (beat_done) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last_beat)     state_q <= we_q ? ST_IDLE : ST_RESP;
          else if (!burst_q) state_q <= ST_CMD;  // one command per beat
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign we_o          = we_q;
  assign burst_o       = burst_q;
  assign cnt_o         = cnt_q;
  assign cmd_valid_o   = (state_q == ST_CMD);
  assign wbeat_valid_o = (state_q == ST_DATA) && we_q;
  assign rcap_o        = beat_done && !we_q;
  assign rsp_valid_o   = (state_q == ST_RESP);

  p_busy_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  p_rsp_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
  p_cmd_drop_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ack_i |=> !cmd_valid_o);
endmodule

// File: rtl/simd_addr_map.sv
module simd_addr_map #(
  parameter int LADDR_W = 24,
  parameter int CNT_W   = 2,
  parameter int PADDR_W = LADDR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [LADDR_W-1:0] laddr_i,
  input  logic               burst_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [PADDR_W-1:0] paddr_o
);
  logic [PADDR_W-1:0] base_q;

  // word address -> halfword address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (load_i) base_q <= {laddr_i, 1'b0};
  end

  assign paddr_o = burst_i ? base_q : base_q + PADDR_W'(cnt_i);

  p_sdr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_i && $stable(burst_i) && !load_i && cnt_i != '0 && cnt_i != $past(cnt_i)
    |-> paddr_o == $past(paddr_o) + PADDR_W'(1));
endmodule

// File: rtl/simd_beat_pack.sv
module simd_beat_pack #(
  parameter int DATA_W = 64,
  parameter int BEAT_W = 16,
  parameter int NBEAT  = DATA_W / BEAT_W,
  parameter int CNT_W  = $clog2(NBEAT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              rcap_i,
  input  logic [BEAT_W-1:0] rbeat_i,
  output logic [BEAT_W-1:0] wbeat_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] wbuf_q;
  logic [BEAT_W-1:0] wslice [NBEAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wbuf_q <= '0;
    else if (load_i) wbuf_q <= wdata_i;
  end

  // beat k carries halfword k, low half of the explicit word first
  for (genvar g = 0; g < NBEAT; g++) begin : g_lane
    logic [BEAT_W-1:0] rlane_q;
    assign wslice[g] = wbuf_q[g*BEAT_W +: BEAT_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             rlane_q <= '0;
      else if (rcap_i && cnt_i == CNT_W'(g))   rlane_q <= rbeat_i;
    end
    assign rdata_o[g*BEAT_W +: BEAT_W] = rlane_q;
  end

  assign wbeat_o = wslice[cnt_i];

  p_wbuf_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(wbuf_q));
endmodule

// File: rtl/simd_x16_seq.sv
module simd_x16_seq #(
  parameter int LADDR_W = 24,
  parameter int DATA_W  = 64,
  parameter int BEAT_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [LADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic                req_we_i,
  input  logic                req_ddr_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                cmd_valid_o,
  input  logic                cmd_ack_i,
  output logic                cmd_we_o,
  output logic                cmd_burst_o,
  output logic [LADDR_W:0]    cmd_addr_o,
  output logic                wbeat_valid_o,
  input  logic                wbeat_ready_i,
  output logic [BEAT_W-1:0]   wbeat_data_o,
  output logic [BEAT_W/8-1:0] wbeat_mask_o,
  input  logic                rbeat_valid_i,
  input  logic [BEAT_W-1:0]   rbeat_data_i
);
  localparam int NBEAT   = DATA_W / BEAT_W;
  localparam int CNT_W   = $clog2(NBEAT);
  localparam int PADDR_W = LADDR_W + 1;
  localparam int MASK_W  = BEAT_W / 8;

  logic             load, rcap;
  logic [CNT_W-1:0] cnt;

  simd_seq_ctrl #(.NBEAT(NBEAT), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_we_i, .req_ddr_i,
    .cmd_ack_i, .wbeat_ready_i, .rbeat_valid_i,
    .req_ready_o, .load_o(load), .we_o(cmd_we_o), .burst_o(cmd_burst_o),
    .cnt_o(cnt), .cmd_valid_o, .wbeat_valid_o, .rcap_o(rcap), .rsp_valid_o
  );

  simd_addr_map #(.LADDR_W(LADDR_W), .CNT_W(CNT_W), .PADDR_W(PADDR_W)) u_amap (
    .clk_i, .rst_ni, .load_i(load), .laddr_i(req_addr_i),
    .burst_i(cmd_burst_o), .cnt_i(cnt), .paddr_o(cmd_addr_o)
  );

  simd_beat_pack #(.DATA_W(DATA_W), .BEAT_W(BEAT_W), .NBEAT(NBEAT), .CNT_W(CNT_W)) u_pack (
    .clk_i, .rst_ni, .load_i(load), .wdata_i(req_wdata_i), .cnt_i(cnt),
    .rcap_i(rcap), .rbeat_i(rbeat_data_i), .wbeat_o(wbeat_data_o), .rdata_o(rsp_rdata_o)
  );

  // full SIMD write: every lane enabled
  assign wbeat_mask_o = wbeat_valid_o ? '0 : {MASK_W{1'b1}};

  p_cmd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_addr_o));
  p_base_even_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_burst_o |-> !cmd_addr_o[0]);
  p_no_beat_in_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !wbeat_valid_o && !rsp_valid_o);
endmodule

// File: tb/simd_x16_seq_test.sv
module simd_x16_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0, req_ddr_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o, cmd_valid_o, cmd_we_o, cmd_burst_o, wbeat_valid_o;
  logic [63:0] rsp_rdata_o;
  logic [24:0] cmd_addr_o;
  logic [15:0] wbeat_data_o;
  logic [1:0]  wbeat_mask_o;
  logic        cmd_ack_i, wbeat_ready_i, rbeat_valid_i;
  logic [15:0] rbeat_data_i;

  int nchk = 0, nfail = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  simd_x16_seq uut (.*);

  // memory model and logs
  logic [15:0] mem [256];
  logic [24:0] cmd_a [64];
  logic        cmd_b [64], cmd_w [64];
  logic [24:0] bt_a [64];
  logic [15:0] bt_d [64];
  logic [1:0]  bt_m [64];
  int          ncmd, nbeat, hold_err, cyc, pend;
  logic [24:0] cur, pca;
  logic        pcv;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_ack_i <= 1'b0; wbeat_ready_i <= 1'b0; rbeat_valid_i <= 1'b0; rbeat_data_i <= '0;
      ncmd <= 0; nbeat <= 0; hold_err <= 0; cyc <= 0; pend <= 0; cur <= '0;
      pcv <= 1'b0; pca <= '0;
    end else begin
      cyc <= cyc + 1;
      pcv <= cmd_valid_o && !cmd_ack_i;
      pca <= cmd_addr_o;
      if (pcv && !(cmd_valid_o && cmd_addr_o == pca)) hold_err <= hold_err + 1;
      cmd_ack_i     <= cmd_valid_o && !cmd_ack_i && (cyc % 3 == 2);
      wbeat_ready_i <= wbeat_valid_o && !wbeat_ready_i && (cyc % 2 == 1);
      rbeat_valid_i <= 1'b0;
      if (cmd_valid_o && cmd_ack_i) begin
        cmd_a[ncmd % 64] <= cmd_addr_o;
        cmd_b[ncmd % 64] <= cmd_burst_o;
        cmd_w[ncmd % 64] <= cmd_we_o;
        ncmd <= ncmd + 1;
        cur  <= cmd_addr_o;
        pend <= cmd_burst_o ? 4 : 1;
      end else if (wbeat_valid_o && wbeat_ready_i) begin
        mem[cur[7:0]]     <= wbeat_data_o;
        bt_a[nbeat % 64]  <= cur;
        bt_d[nbeat % 64]  <= wbeat_data_o;
        bt_m[nbeat % 64]  <= wbeat_mask_o;
        nbeat <= nbeat + 1;
        cur   <= cur + 1;
        pend  <= pend - 1;
      end else if (!cmd_we_o && pend > 0 && !rbeat_valid_i) begin
        rbeat_valid_i    <= 1'b1;
        rbeat_data_i     <= mem[cur[7:0]];
        bt_a[nbeat % 64] <= cur;
        bt_d[nbeat % 64] <= mem[cur[7:0]];
        bt_m[nbeat % 64] <= 2'b00;
        nbeat <= nbeat + 1;
        cur   <= cur + 1;
        pend  <= pend - 1;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [23:0] la, input logic [63:0] wd, input logic we, input logic ddr);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = la; req_wdata_i = wd; req_we_i = we; req_ddr_i = ddr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(!req_ready_o, "R7 ready low after accept", 64'(req_ready_o), 64'd0);
  endtask

  task automatic check_cmds(input int c0, input int b0, input logic [24:0] n,
                            input logic we, input logic ddr, input logic [63:0] data);
    chk(ncmd - c0 == (ddr ? 1 : 4), ddr ? "R4 command count" : "R3 command count",
        64'(ncmd - c0), ddr ? 64'd1 : 64'd4);
    chk(n == cmd_a[c0 % 64], "R1 first command address", 64'(cmd_a[c0 % 64]), 64'(n));
    for (int i = 0; i < (ddr ? 1 : 4); i++) begin
      chk(cmd_a[(c0 + i) % 64] == n + 25'(i), "R3 command address", 64'(cmd_a[(c0 + i) % 64]), 64'(n + 25'(i)));
      chk(cmd_b[(c0 + i) % 64] == ddr, "R4 burst flag", 64'(cmd_b[(c0 + i) % 64]), 64'(ddr));
      chk(cmd_w[(c0 + i) % 64] == we, "R10 command direction", 64'(cmd_w[(c0 + i) % 64]), 64'(we));
    end
    chk(nbeat - b0 == 4, "R3 R4 beat count", 64'(nbeat - b0), 64'd4);
    for (int i = 0; i < 4; i++) begin
      chk(bt_a[(b0 + i) % 64] == n + 25'(i), "R2 beat address", 64'(bt_a[(b0 + i) % 64]), 64'(n + 25'(i)));
      chk(bt_d[(b0 + i) % 64] == data[i*16 +: 16], "R2 beat data", 64'(bt_d[(b0 + i) % 64]), 64'(data[i*16 +: 16]));
      if (we) chk(bt_m[(b0 + i) % 64] == 2'b00, "R5 write mask", 64'(bt_m[(b0 + i) % 64]), 64'd0);
    end
    chk(hold_err == 0, "R6 command held until ack", 64'(hold_err), 64'd0);
  endtask

  task automatic t_write(input logic [23:0] la, input logic [63:0] wd, input logic ddr);
    int c0, b0;
    c0 = ncmd; b0 = nbeat;
    issue(la, wd, 1'b1, ddr);
    while (!req_ready_o) @(negedge clk_i);
    chk(nbeat - b0 == 4, "R7 ready returns after last write beat", 64'(nbeat - b0), 64'd4);
    check_cmds(c0, b0, {la, 1'b0}, 1'b1, ddr, wd);
  endtask

  task automatic t_read(input logic [23:0] la, input logic ddr, input logic [63:0] exp);
    int c0, b0;
    logic [63:0] got;
    c0 = ncmd; b0 = nbeat;
    issue(la, 64'h0, 1'b0, ddr);
    while (!rsp_valid_o) begin
      chk(!req_ready_o, "R7 ready low during read", 64'(req_ready_o), 64'd0);
      @(negedge clk_i);
    end
    got = rsp_rdata_o;
    chk(!req_ready_o, "R7 ready low with response", 64'(req_ready_o), 64'd0);
    chk(got == exp, "R8 read data", got, exp);
    @(negedge clk_i);
    chk(!rsp_valid_o && req_ready_o, "R8 single response cycle",
        {62'd0, rsp_valid_o, req_ready_o}, 64'd1);
    check_cmds(c0, b0, {la, 1'b0}, 1'b0, ddr, exp);
  endtask

  task automatic t_reset();
    #1;
    chk(req_ready_o == 1'b1, "R9 reset ready", 64'(req_ready_o), 64'd1);
    chk(!cmd_valid_o && !wbeat_valid_o && !rsp_valid_o, "R9 reset idle outputs",
        {61'd0, cmd_valid_o, wbeat_valid_o, rsp_valid_o}, 64'd0);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_write(24'h200000, 64'h8877_6655_4433_2211, 1'b0);  // R1 physical 0x400000
    t_read (24'h200000, 1'b0, 64'h8877_6655_4433_2211);
    t_write(24'h000021, 64'hF00D_CAFE_BEEF_1234, 1'b1);
    t_read (24'h000021, 1'b1, 64'hF00D_CAFE_BEEF_1234);
    t_read (24'h200000, 1'b1, 64'h8877_6655_4433_2211);  // cross-mode
    t_write(24'h000010, 64'h0123_4567_89AB_CDEF, 1'b1);
    t_read (24'h000010, 1'b0, 64'h0123_4567_89AB_CDEF);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    nchk++; nfail++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule